// File: doc/BRIEF.md
# Interrupt-on-change GPIO port

This block is a general-purpose I/O port with a parameterised pin count (eight by default) behind a register bus that moves one byte at a time. The bus carries an address, a select flag, write and read strobes and the write data. Read data comes back registered, one cycle after the read strobe. On the pin side, the port drives an output value, a per-pin output enable and a per-pin pull-up enable. It samples its input pins through a synchroniser chain of parameterised depth, and it drives one interrupt pin.

Each pin with its interrupt enabled is watched in one of two modes. In change mode it fires when its synchronised level differs from the level it had one cycle earlier. In compare mode it fires while its level differs from a programmed default bit. An interrupt is tracked by a two-state machine:

- `IRQ_IDLE` moves to `IRQ_PENDING` on the transition named "hit", which happens when any enabled pin fires.
- `IRQ_PENDING` moves back to `IRQ_IDLE` on the transition named "clear", which is a read of the clearing register.

On the hit transition, the flag register records only the lowest-numbered firing pin, and the capture register takes a snapshot of all pin levels. Both stay frozen until the interrupt is cleared.

When a bus access does not assert the select flag, it uses an internal address pointer. Unless sequential operation is disabled, that pointer steps forward after every access.

Top module: `ioc_port`

## Requirements
- R1: After reset, the direction register (address 0x00) reads all ones, so `pin_oe` is zero and every pin is an input. Every other writable register reads zero, the address pointer is 0x00 and the interrupt is inactive.
- R2: The register map is as follows:
  - 0x00 direction (1 = input)
  - 0x01 input inversion
  - 0x02 interrupt enable
  - 0x03 default compare
  - 0x04 mode (1 = compare against default, 0 = change)
  - 0x05 configuration
  - 0x06 pull-up
  - 0x07 flag
  - 0x08 capture
  - 0x09 port
  - 0x0A output latch

  Writes to 0x07, 0x08 and to addresses above 0x0A are ignored, and reads of addresses above 0x0A return zero. Read data appears on `bus_rdata` one cycle after `bus_rd` and is held until the next read.
- R3: The configuration register uses these bits:
  - bit 6: mirror (stored only)
  - bit 5: sequential-operation disable
  - bit 3: address enable (stored only)
  - bit 2: open-drain interrupt
  - bit 1: interrupt active level
  - bit 0: clear-by-capture

  Bits 7 and 4 always read zero.
- R4: A port read returns the synchronised pin level XOR the inversion bit for input pins, and the latch bit for output pins. A write to 0x09 or 0x0A updates the latch. `pin_out` follows the latch, `pin_oe` is the inverse of the direction register and `pin_pu` follows the pull-up register.
- R5: A pin change reaches the synchronised level after SYNC_STAGES clock edges.
- R6: In change mode, an enabled pin fires when its synchronised level differs from the level it had one cycle earlier.
- R7: In compare mode, an enabled pin fires whenever its synchronised level differs from its default bit. The pin fires again right after a clear if the mismatch is still there.
- R8: On the hit transition, the flag register holds a single bit for the lowest-numbered firing pin, and the capture register holds all synchronised pin levels.
- R9: While pending, the flag and capture registers do not change, whatever the pins do.
- R10: With configuration bit 0 at zero, a port read clears the interrupt and a capture read does not. With bit 0 at one, a capture read clears it and a port read does not. A clear returns the flag register to zero.
- R11: When the port is not in open-drain mode, `irq_oe` is 1 and `irq_o` equals configuration bit 1 while pending and its inverse otherwise. In open-drain mode, `irq_o` is 0, `irq_oe` is 1 only while pending, and bit 1 has no effect.
- R12: With configuration bit 5 at zero, every access steps the pointer by one, and it wraps from 0x0A (or above) to 0x00. With bit 5 at one, the pointer stays on the address just accessed. An access with `bus_sel` high uses `bus_addr`; otherwise it uses the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Use `bus_addr` for this access instead of the pointer |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data |
| pin_in | input | W | Asynchronous input pins |
| pin_out | output | W | Output pin values |
| pin_oe | output | W | Per-pin output enable |
| pin_pu | output | W | Per-pin pull-up enable |
| irq_o | output | 1 | Interrupt pin value |
| irq_oe | output | 1 | Interrupt pin drive enable |

## Verification
The bench builds the port with W = 8 and SYNC_STAGES = 3, one stage deeper than the default. This shows whether the pin-to-register latency and the edge at which change mode fires follow the parameter rather than a fixed two-flop delay. The reference model shifts pins through a chain of that depth and replays the interrupt rules against it. This brings within reach simultaneous changes on several pins, compare-mode refiring after a clear, both clear sources, and pointer wraparound.

// File: rtl/ioc_pkg.sv
`timescale 1ns/1ps
package ioc_pkg;
    localparam logic [7:0] A_DIR  = 8'h00;
    localparam logic [7:0] A_INV  = 8'h01;
    localparam logic [7:0] A_IEN  = 8'h02;
    localparam logic [7:0] A_DEF  = 8'h03;
    localparam logic [7:0] A_MODE = 8'h04;
    localparam logic [7:0] A_CFG  = 8'h05;
    localparam logic [7:0] A_PUP  = 8'h06;
    localparam logic [7:0] A_FLAG = 8'h07;
    localparam logic [7:0] A_CAP  = 8'h08;
    localparam logic [7:0] A_PORT = 8'h09;
    localparam logic [7:0] A_LAT  = 8'h0A;
    localparam logic [7:0] A_LAST = A_LAT;

    localparam int CFG_NOSEQ  = 5;
    localparam int CFG_OD     = 2;
    localparam int CFG_LEVEL  = 1;
    localparam int CFG_CLRCAP = 0;
    localparam logic [7:0] CFG_WMASK = 8'h6F;

    typedef enum logic {
        IRQ_IDLE    = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_e;
endpackage

// File: rtl/ioc_sync.sv
`timescale 1ns/1ps
module ioc_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ioc_irq_fsm.sv
`timescale 1ns/1ps
module ioc_irq_fsm
    import ioc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] en,
    input  logic [W-1:0] mode,
    input  logic [W-1:0] defv,
    input  logic         clr,
    output logic         pend,
    output logic [W-1:0] flag,
    output logic [W-1:0] cap
);
    irq_state_e state_q, state_d;
    logic [W-1:0] prev_q;
    logic [W-1:0] hit;
    logic [W-1:0] first;

    // Per-pin firing condition: compare mode against default, else change.
    assign hit   = en & ((mode & (pins ^ defv)) | (~mode & (pins ^ prev_q)));
    // Lowest set bit of hit.
    assign first = hit & (~hit + W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= pins;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:    if (|hit) state_d = IRQ_PENDING;
            IRQ_PENDING: if (clr)  state_d = IRQ_IDLE;
            default:     state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= '0;
            cap  <= '0;
        end else begin
            unique case (state_q)
                IRQ_IDLE: begin
                    if (|hit) begin
                        flag <= first;
                        cap  <= pins;
                    end
                end
                IRQ_PENDING: begin
                    if (clr) flag <= '0;
                end
                default: flag <= '0;
            endcase
        end
    end

    assign pend = (state_q == IRQ_PENDING);
endmodule

// File: rtl/ioc_port.sv
`timescale 1ns/1ps
module ioc_port
    import ioc_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_sel,
    input  logic [7:0]   bus_addr,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_pu,
    output logic         irq_o,
    output logic         irq_oe
);
    logic [W-1:0] dir_q, inv_q, ien_q, def_q, mode_q, pup_q, lat_q;
    logic [7:0]   cfg_q;
    logic [7:0]   ptr_q;
    logic [7:0]   eff_addr;
    logic [W-1:0] pins_s;
    logic [W-1:0] port_val;
    logic [W-1:0] rd_val;
    logic [W-1:0] flag_w, cap_w;
    logic [W-1:0] rdata_q;
    logic         pend_w;
    logic         clr_w;

    ioc_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pins_s)
    );

    ioc_irq_fsm #(.W(W)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (pins_s),
        .en    (ien_q),
        .mode  (mode_q),
        .defv  (def_q),
        .clr   (clr_w),
        .pend  (pend_w),
        .flag  (flag_w),
        .cap   (cap_w)
    );

    assign eff_addr = bus_sel ? bus_addr : ptr_q;
    assign port_val = (dir_q & (pins_s ^ inv_q)) | (~dir_q & lat_q);
    assign clr_w    = bus_rd && (cfg_q[CFG_CLRCAP] ? (eff_addr == A_CAP)
                                                   : (eff_addr == A_PORT));

    always_comb begin
        case (eff_addr)
            A_DIR:   rd_val = dir_q;
            A_INV:   rd_val = inv_q;
            A_IEN:   rd_val = ien_q;
            A_DEF:   rd_val = def_q;
            A_MODE:  rd_val = mode_q;
            A_CFG:   rd_val = W'(cfg_q);
            A_PUP:   rd_val = pup_q;
            A_FLAG:  rd_val = flag_w;
            A_CAP:   rd_val = cap_w;
            A_PORT:  rd_val = port_val;
            A_LAT:   rd_val = lat_q;
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '1;
            inv_q   <= '0;
            ien_q   <= '0;
            def_q   <= '0;
            mode_q  <= '0;
            cfg_q   <= '0;
            pup_q   <= '0;
            lat_q   <= '0;
            ptr_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (bus_rd) rdata_q <= rd_val;
            if (bus_wr) begin
                case (eff_addr)
                    A_DIR:          dir_q  <= bus_wdata;
                    A_INV:          inv_q  <= bus_wdata;
                    A_IEN:          ien_q  <= bus_wdata;
                    A_DEF:          def_q  <= bus_wdata;
                    A_MODE:         mode_q <= bus_wdata;
                    A_CFG:          cfg_q  <= bus_wdata[7:0] & CFG_WMASK;
                    A_PUP:          pup_q  <= bus_wdata;
                    A_PORT, A_LAT:  lat_q  <= bus_wdata;
                    default:        ;
                endcase
            end
            if (bus_wr || bus_rd) begin
                if (cfg_q[CFG_NOSEQ])       ptr_q <= eff_addr;
                else if (eff_addr >= A_LAST) ptr_q <= 8'h00;
                else                         ptr_q <= eff_addr + 8'h01;
            end
        end
    end

    assign bus_rdata = rdata_q;
    assign pin_out   = lat_q;
    assign pin_oe    = ~dir_q;
    assign pin_pu    = pup_q;
    assign irq_oe    = cfg_q[CFG_OD] ? pend_w : 1'b1;
    assign irq_o     = cfg_q[CFG_OD] ? 1'b0 : (pend_w ~^ cfg_q[CFG_LEVEL]);
endmodule

// File: rtl/ioc_port_chk.sv
`timescale 1ns/1ps
module ioc_port_chk
    import ioc_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pend,
    input logic [W-1:0] flag,
    input logic [W-1:0] cap,
    input logic         clr,
    input logic         rd,
    input logic [7:0]   addr,
    input logic [W-1:0] rdata,
    input logic [7:0]   cfg,
    input logic         irq_o
);
    a_r8_flag_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag));

    a_r8_flag_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> (flag != '0));

    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> ($stable(cap) && $stable(flag)));

    a_r10_port_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == A_PORT && !cfg[CFG_CLRCAP]) |=> !pend);

    a_r10_cap_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == A_CAP && cfg[CFG_CLRCAP]) |=> !pend);

    a_r10_port_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && rd && addr == A_PORT && cfg[CFG_CLRCAP]) |=> pend);

    a_r3_cfg_gaps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == A_CFG) |=> (rdata[7] == 1'b0 && rdata[4] == 1'b0));

    a_r11_od_low: assert property (@(posedge clk) disable iff (!rst_n)
        cfg[CFG_OD] |-> !irq_o);
endmodule

bind ioc_port ioc_port_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend_w),
    .flag  (flag_w),
    .cap   (cap_w),
    .clr   (clr_w),
    .rd    (bus_rd),
    .addr  (eff_addr),
    .rdata (bus_rdata),
    .cfg   (cfg_q),
    .irq_o (irq_o)
);

// File: tb/ioc_port_bench.sv
`timescale 1ns/1ps
module ioc_port_bench;
    localparam int W  = 8;
    localparam int SS = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic         bus_sel = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out, pin_oe, pin_pu;
    logic         irq_o, irq_oe;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    ioc_port #(.W(W), .SYNC_STAGES(SS)) u_ioc_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pu(pin_pu), .irq_o(irq_o), .irq_oe(irq_oe)
    );

    // Behavioural reference model
    logic [W-1:0] m_sync [SS];
    logic [W-1:0] m_prev, m_dir, m_inv, m_ien, m_def, m_mode, m_pup, m_lat;
    logic [W-1:0] m_flag, m_cap, m_rdata;
    logic [7:0]   m_cfg, m_ptr;
    bit           m_pend;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SS; i++) m_sync[i] = '0;
            m_prev = '0; m_dir = '1; m_inv = '0; m_ien = '0; m_def = '0;
            m_mode = '0; m_pup = '0; m_lat = '0; m_flag = '0; m_cap = '0;
            m_rdata = '0; m_cfg = '0; m_ptr = '0; m_pend = 0;
        end else begin
            logic [7:0]   a;
            logic [W-1:0] p, pv, rv, hit, first;
            bit           clr;
            a  = bus_sel ? bus_addr : m_ptr;
            p  = m_sync[SS-1];
            pv = '0;
            for (int i = 0; i < W; i++)
                pv[i] = m_dir[i] ? (p[i] ^ m_inv[i]) : m_lat[i];
            case (a)
                8'h00: rv = m_dir;   8'h01: rv = m_inv;  8'h02: rv = m_ien;
                8'h03: rv = m_def;   8'h04: rv = m_mode; 8'h05: rv = m_cfg;
                8'h06: rv = m_pup;   8'h07: rv = m_flag; 8'h08: rv = m_cap;
                8'h09: rv = pv;      8'h0A: rv = m_lat;  default: rv = '0;
            endcase
            hit = '0;
            for (int i = 0; i < W; i++)
                if (m_ien[i] && (m_mode[i] ? (p[i] != m_def[i]) : (p[i] != m_prev[i])))
                    hit[i] = 1'b1;
            first = '0;
            for (int i = W - 1; i >= 0; i--)
                if (hit[i]) first = W'(1) << i;
            clr = bus_rd && (m_cfg[0] ? (a == 8'h08) : (a == 8'h09));
            if (!m_pend) begin
                if (hit != '0) begin m_pend = 1; m_flag = first; m_cap = p; end
            end else if (clr) begin
                m_pend = 0; m_flag = '0;
            end
            if (bus_rd) m_rdata = rv;
            if (bus_wr) begin
                case (a)
                    8'h00: m_dir = bus_wdata;  8'h01: m_inv = bus_wdata;
                    8'h02: m_ien = bus_wdata;  8'h03: m_def = bus_wdata;
                    8'h04: m_mode = bus_wdata; 8'h05: m_cfg = bus_wdata & 8'h6F;
                    8'h06: m_pup = bus_wdata;  8'h09, 8'h0A: m_lat = bus_wdata;
                    default: ;
                endcase
            end
            if (bus_wr || bus_rd)
                m_ptr = m_cfg[5] ? a : ((a >= 8'h0A) ? 8'h00 : a + 8'h01);
            m_prev = p;
            for (int i = SS - 1; i > 0; i--) m_sync[i] = m_sync[i-1];
            m_sync[0] = pin_in;
        end
    end

    task automatic cmp(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare every clock, 2 ns after the rising edge.
    always @(posedge clk) begin
        #2;
        if (!done) begin
            logic eo, eoe;
            eoe = m_cfg[2] ? m_pend : 1'b1;
            eo  = m_cfg[2] ? 1'b0 : (m_pend ? m_cfg[1] : ~m_cfg[1]);
            cmp("rdata",  bus_rdata, m_rdata);
            cmp("pin_out", pin_out, m_lat);
            cmp("pin_oe",  pin_oe, ~m_dir);
            cmp("pin_pu",  pin_pu, m_pup);
            cmp("irq_o",   W'(irq_o), W'(eo));
            cmp("irq_oe",  W'(irq_oe), W'(eoe));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_sel = 1; bus_addr = a; bus_wr = 1; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        bus_sel = 1; bus_addr = a; bus_rd = 1;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic rd_next();
        @(negedge clk);
        bus_sel = 0; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic pins(input logic [W-1:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        #1 rst_n = 0;
        #20 rst_n = 1;
        cur_req = "R1"; idle(3);
        for (int a = 0; a < 12; a++) rd(8'(a));

        cur_req = "R2";
        wr(8'h01, 8'h5A); wr(8'h02, 8'h00); wr(8'h03, 8'hC3); wr(8'h06, 8'h99);
        wr(8'h07, 8'hFF); wr(8'h08, 8'hFF); wr(8'h0C, 8'hFF); wr(8'h04, 8'h00);
        for (int a = 0; a < 14; a++) rd(8'(a));

        cur_req = "R3";
        wr(8'h05, 8'hFF); rd(8'h05); wr(8'h05, 8'h00); rd(8'h05);

        cur_req = "R4";
        wr(8'h00, 8'h0F); wr(8'h01, 8'h05); wr(8'h09, 8'hA5); pins(8'h3C);
        idle(4); rd(8'h09); wr(8'h0A, 8'h3C); rd(8'h09); rd(8'h0A);

        cur_req = "R5";
        pins(8'h0A);
        for (int i = 0; i < 5; i++) rd(8'h09);

        cur_req = "R12";
        rd(8'h08); rd_next(); rd_next(); rd_next(); rd_next(); rd_next();
        wr(8'h05, 8'h20); rd(8'h03); rd_next(); rd_next();
        @(negedge clk); bus_wr = 1; bus_wdata = 8'h77; @(negedge clk); bus_wr = 0;
        wr(8'h05, 8'h00); wr(8'h0B, 8'h00); rd_next();

        cur_req = "R6";
        wr(8'h00, 8'hFF); wr(8'h01, 8'h00); pins(8'h00); idle(5);
        wr(8'h02, 8'hFF); wr(8'h04, 8'h00);
        cur_req = "R8";
        pins(8'h28); idle(6); rd(8'h07); rd(8'h08);
        cur_req = "R9";
        pins(8'hC1); idle(6); rd(8'h07); rd(8'h08);
        cur_req = "R10";
        rd(8'h08); rd(8'h09); idle(3); rd(8'h07);

        cur_req = "R7";
        wr(8'h04, 8'h02); wr(8'h03, 8'h00); pins(8'hC3); idle(6);
        rd(8'h07); rd(8'h09); idle(2); rd(8'h07); rd(8'h08);

        cur_req = "R10";
        wr(8'h05, 8'h01); rd(8'h09); idle(2); rd(8'h08); idle(2);
        wr(8'h02, 8'h00); rd(8'h08); rd(8'h09); idle(2);

        cur_req = "R11";
        wr(8'h05, 8'h02); wr(8'h04, 8'h00); wr(8'h02, 8'h10); pins(8'hD3); idle(6);
        wr(8'h05, 8'h06); idle(2); wr(8'h05, 8'h04); idle(2);
        rd(8'h09); idle(3); wr(8'h05, 8'h00); idle(2);

        finish_run();
    end
endmodule